// File: doc/BRIEF.md
# Weighted-Credit Round-Robin Output Scheduler

This block decides, once per cycle, which input queue of a router may send its head flit through one output port. Each input that holds a flit bound for this output raises a request line and presents that flit's 2-bit priority tag. The scheduler returns a one-hot grant and a grant-valid flag. The decision is made afresh for every flit, so flits from different flows interleave on the same link.

Priority acts through credits rather than as an absolute order. Each of the four levels has a weight, set by a parameter, and a credit counter that starts at that weight. The highest requesting level that still holds credit wins. Each accepted grant spends one credit of the winning level. When requesters are present but none of their levels has credit, every counter reloads to its weight. Low-priority traffic therefore gets a bounded share of grants and is never starved. Requesters at the same level take turns through a round-robin pointer kept for that level.

A requester that is alone is granted at once and spends no credit, so the link is never left idle. The surrounding logic raises `accept` when the granted flit actually moves. State advances only on an accepted grant.

Top module: `prio_rr_sched`

## Requirements
- R1: `gnt` has at most one bit set. `gnt_vld` is high exactly when `gnt` is non-zero. A grant goes only to a requester whose `req` bit is high.
- R2: With `req` all zero, `gnt_vld` is low, and neither the credits nor the pointers change, whatever `accept` is.
- R3: Requester i's priority level is `prio[2i+1:2i]`. Level 3 is the highest. When two or more requesters are present, the grant goes to the highest requesting level whose credit is non-zero.
- R4: Each level has its own round-robin pointer. Among the requesters of the winning level, the first one found searching upward from that pointer, with wrap-around, is granted. An accepted grant moves the pointer to the index just past the granted requester.
- R5: An accepted grant with two or more requesters lowers the winning level's credit by one. A level whose credit is zero cannot win while another requesting level still holds credit.
- R6: When requesters are present and no requesting level holds credit, the decision is made as if every credit equalled its weight. On acceptance, all credits reload to their weights, minus one for the winning level.
- R7: Credits and pointers change only in a cycle where `gnt_vld` and `accept` are both high. A grant that is not accepted is offered again unchanged if the inputs stay the same.
- R8: When exactly one `req` bit is high, that requester is granted whatever its level's credit. An accepted grant of this kind spends no credit but still moves that level's pointer.
- R9: With one requester per level and all of them requesting continuously with every grant accepted, each requester receives weight/(sum of weights) of the grants over whole rounds. Each is granted at least once in every window of (sum of weights) cycles.
- R10: Reset sets every credit to its level's weight and every pointer to requester 0. Each weight must lie between 1 and 2^CRED_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_REQ | One request line per input queue with a head flit for this output |
| prio | input | 2*N_REQ | Priority tag of each requester's head flit, 2 bits per requester |
| accept | input | 1 | The granted flit is taken this cycle |
| gnt | output | N_REQ | One-hot grant |
| gnt_vld | output | 1 | A grant is offered this cycle |

## Verification
The bench builds the block with four requesters, 3-bit credits and level weights 1, 1, 2 and 3 (low to high). A full round is then only seven grants. Credit exhaustion, reload, lone-requester bypass and pointer wrap all occur within a few dozen cycles. Because levels 0 and 1 share a weight, both reload triggers can be reached: a higher level still holding credit while only drained lower levels request, and all levels drained at once. The 70-cycle continuous run covers ten whole rounds, so the expected grant counts (10, 10, 20, 30) and the seven-cycle fairness bound are exact rather than approximate.

// File: rtl/psch_pkg.sv
package psch_pkg;
  // Width of a flit's priority tag and the number of levels it encodes
  localparam int unsigned LVL_W = 2;
  localparam int unsigned N_LVL = 1 << LVL_W;
endpackage

// File: rtl/psch_rr_level.sv
// Round-robin picker for one priority level, with its own pointer.
module psch_rr_level #(
  parameter int unsigned N_REQ = 4,
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] cand,
  input  logic             adv,
  output logic [N_REQ-1:0] pick
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic [IDX_W-1:0] pick_idx;
  logic             found;

  function automatic int unsigned wrap_idx(input int unsigned base, input int unsigned off);
    return (base + off) % N_REQ;
  endfunction

  // search upward from the pointer, first candidate wins
  always_comb begin
    pick     = '0;
    pick_idx = '0;
    found    = 1'b0;
    for (int unsigned k = 0; k < N_REQ; k++) begin
      if (!found && cand[wrap_idx(int'(ptr_q), k)]) begin
        found                         = 1'b1;
        pick[wrap_idx(int'(ptr_q), k)] = 1'b1;
        pick_idx                      = IDX_W'(wrap_idx(int'(ptr_q), k));
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv && found) begin
      if (pick_idx == IDX_W'(N_REQ - 1)) ptr_d = '0;
      else                               ptr_d = pick_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

endmodule

// File: rtl/psch_credit_bank.sv
// Per-level credit counters with spend and reload.
module psch_credit_bank
  import psch_pkg::*;
#(
  parameter int unsigned           CRED_W  = 4,
  parameter logic [N_LVL*CRED_W-1:0] WEIGHTS = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             reload,
  input  logic [LVL_W-1:0] lvl,
  output logic [N_LVL-1:0] has_cred
);

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    localparam logic [CRED_W-1:0] WT = WEIGHTS[l*CRED_W +: CRED_W];
    logic [CRED_W-1:0] cred_q;
    logic [CRED_W-1:0] cred_d;
    logic              hit;
    logic              en;

    assign hit = take && (lvl == LVL_W'(l));
    assign en  = reload || hit;

    always_comb begin
      cred_d = cred_q;
      if (reload)   cred_d = hit ? (WT - 1'b1) : WT;
      else if (hit) cred_d = cred_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cred_q <= WT;
      else if (en) cred_q <= cred_d;
    end

    assign has_cred[l] = (cred_q != '0);
  end

endmodule

// File: rtl/psch_level_sel.sv
// Picks the highest level set in the eligibility mask.
module psch_level_sel
  import psch_pkg::*;
(
  input  logic [N_LVL-1:0] ok,
  output logic [LVL_W-1:0] win_lvl
);

  always_comb begin
    win_lvl = '0;
    for (int unsigned l = 0; l < N_LVL; l++) begin
      if (ok[l]) win_lvl = LVL_W'(l);
    end
  end

endmodule

// File: rtl/prio_rr_sched.sv
module prio_rr_sched
  import psch_pkg::*;
#(
  parameter int unsigned N_REQ  = 4,
  parameter int unsigned CRED_W = 4,
  parameter int unsigned WT_L0  = 1,
  parameter int unsigned WT_L1  = 2,
  parameter int unsigned WT_L2  = 3,
  parameter int unsigned WT_L3  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REQ-1:0]       req,
  input  logic [LVL_W*N_REQ-1:0] prio,
  input  logic                   accept,
  output logic [N_REQ-1:0]       gnt,
  output logic                   gnt_vld
);

  localparam logic [N_LVL*CRED_W-1:0] WT_VEC =
    {CRED_W'(WT_L3), CRED_W'(WT_L2), CRED_W'(WT_L1), CRED_W'(WT_L0)};

  logic [N_LVL-1:0][N_REQ-1:0] cand;
  logic [N_LVL-1:0][N_REQ-1:0] pick;
  logic [N_LVL-1:0]            lvl_any;
  logic [N_LVL-1:0]            has_cred;
  logic [N_LVL-1:0]            live;
  logic [N_LVL-1:0]            ok;
  logic [N_LVL-1:0]            adv;
  logic [LVL_W-1:0]            win_lvl;
  logic                        lone;
  logic                        need_reload;
  logic                        fire;
  logic                        take;
  logic                        reload;

  // sort requesters into levels
  for (genvar l = 0; l < N_LVL; l++) begin : g_cand
    for (genvar i = 0; i < N_REQ; i++) begin : g_req
      assign cand[l][i] = req[i] && (prio[i*LVL_W +: LVL_W] == LVL_W'(l));
    end
    assign lvl_any[l] = |cand[l];
    assign live[l]    = lvl_any[l] && has_cred[l];
  end

  assign lone        = $onehot(req);
  assign need_reload = (|req) && !(|live);
  assign ok          = (lone || need_reload) ? lvl_any : live;

  psch_level_sel u_sel (
    .ok      (ok),
    .win_lvl (win_lvl)
  );

  assign gnt     = pick[win_lvl];
  assign gnt_vld = |req;

  assign fire   = accept && gnt_vld;
  assign take   = fire && !lone;
  assign reload = take && need_reload;

  for (genvar l = 0; l < N_LVL; l++) begin : g_rr
    assign adv[l] = fire && (win_lvl == LVL_W'(l));
    psch_rr_level #(.N_REQ(N_REQ)) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .cand  (cand[l]),
      .adv   (adv[l]),
      .pick  (pick[l])
    );
  end

  psch_credit_bank #(.CRED_W(CRED_W), .WEIGHTS(WT_VEC)) u_cred (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .reload   (reload),
    .lvl      (win_lvl),
    .has_cred (has_cred)
  );

endmodule

// File: rtl/psch_chk.sv
module psch_chk
  import psch_pkg::*;
#(
  parameter int unsigned N_REQ = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_REQ-1:0]       req,
  input logic [LVL_W*N_REQ-1:0] prio,
  input logic                   accept,
  input logic [N_REQ-1:0]       gnt,
  input logic                   gnt_vld
);

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && (gnt_vld == (gnt != '0)));

  // R1
  gnt_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !gnt_vld);

  // R8
  lone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(req) |-> (gnt == req));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && !accept) ##1 ($stable(req) && $stable(prio)) |-> $stable(gnt));

endmodule

bind prio_rr_sched psch_chk #(.N_REQ(N_REQ)) u_psch_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .prio    (prio),
  .accept  (accept),
  .gnt     (gnt),
  .gnt_vld (gnt_vld)
);

// File: tb/prio_rr_sched_bench.sv
module prio_rr_sched_bench;

  logic       clk;
  logic       rst_n;
  logic [3:0] req;
  logic [7:0] prio;
  logic       accept;
  logic [3:0] gnt;
  logic       gnt_vld;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  prio_rr_sched #(
    .N_REQ(4), .CRED_W(3), .WT_L0(1), .WT_L1(1), .WT_L2(2), .WT_L3(3)
  ) u_prio_rr_sched (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio),
    .accept(accept), .gnt(gnt), .gnt_vld(gnt_vld)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {req, prio, accept, expected gnt}; prio 8'hFF = all level 3,
  // 8'hE4 = requester i at level i
  localparam logic [16:0] VEC [19] = '{
    {4'b0000, 8'h00, 1'b1, 4'b0000}, // R2 idle
    {4'b0001, 8'hFF, 1'b1, 4'b0001}, // R8 lone, L3 pointer -> 1
    {4'b0011, 8'hFF, 1'b1, 4'b0010}, // R4 from pointer 1
    {4'b0011, 8'hFF, 1'b0, 4'b0001}, // R4 wrap, not accepted
    {4'b0011, 8'hFF, 1'b1, 4'b0001}, // R7 same grant again
    {4'b0011, 8'hFF, 1'b1, 4'b0010}, // R5 L3 credit to 0
    {4'b0011, 8'hFF, 1'b1, 4'b0001}, // R6 reload
    {4'b1111, 8'hE4, 1'b1, 4'b1000}, // R3 highest level
    {4'b1111, 8'hE4, 1'b1, 4'b1000}, // R5 L3 drained
    {4'b1111, 8'hE4, 1'b1, 4'b0100}, // R5 L2 next
    {4'b1111, 8'hE4, 1'b1, 4'b0100},
    {4'b1111, 8'hE4, 1'b1, 4'b0010},
    {4'b1111, 8'hE4, 1'b1, 4'b0001},
    {4'b0000, 8'hE4, 1'b1, 4'b0000}, // R2 idle keeps state
    {4'b1111, 8'hE4, 1'b1, 4'b1000}, // R6 all drained, reload
    {4'b0001, 8'hE4, 1'b1, 4'b0001}, // R8 lone spends nothing
    {4'b0011, 8'hE4, 1'b1, 4'b0010}, // R3 L1 over L0
    {4'b0011, 8'hE4, 1'b1, 4'b0001}, // R5 L1 empty, L0 wins
    {4'b0011, 8'hE4, 1'b1, 4'b0010}  // R6 reload while L2/L3 hold credit
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp || gnt_vld !== (exp != 4'b0000)) begin
      errors++;
      $display("FAIL %s: gnt=%b vld=%b expected gnt=%b vld=%b",
               tag, act, gnt_vld, exp, exp != 4'b0000);
    end
  endtask

  task automatic drive(input logic [3:0] r, input logic [7:0] p, input logic a);
    @(negedge clk);
    req = r; prio = p; accept = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; prio = '0; accept = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  int cnt [4];
  int last [4];
  int max_gap;

  initial begin
    rst_n = 1'b0; req = '0; prio = '0; accept = 1'b0;
    do_reset();

    // R10 full credits: level 3 wins
    drive(4'b1111, 8'hE4, 1'b0);
    check("R10 credits at weight", gnt, 4'b1000);
    // R10 pointer at 0
    drive(4'b0011, 8'hFF, 1'b0);
    check("R10 pointer at 0", gnt, 4'b0001);

    for (int v = 0; v < 19; v++) begin
      drive(VEC[v][16:13], VEC[v][12:5], VEC[v][4]);
      check($sformatf("R3 R4 R5 R6 R7 R8 table vector %0d", v), gnt, VEC[v][3:0]);
    end

    // after the table L1 credit is 0 and L1 pointer is 2; reset must clear both
    do_reset();
    drive(4'b0011, 8'h54, 1'b0);
    check("R10 level 1 credit restored", gnt, 4'b0010);
    drive(4'b0110, 8'h55, 1'b0);
    check("R10 level 1 pointer restored", gnt, 4'b0010);
    drive(4'b0000, 8'h55, 1'b1);
    check("R2 no request", gnt, 4'b0000);

    // R9 continuous load, ten whole rounds
    do_reset();
    for (int i = 0; i < 4; i++) begin cnt[i] = 0; last[i] = 0; end
    max_gap = 0;
    for (int c = 1; c <= 70; c++) begin
      drive(4'b1111, 8'hE4, 1'b1);
      for (int i = 0; i < 4; i++) begin
        if (gnt[i]) begin
          cnt[i]++;
          if (c - last[i] > max_gap) max_gap = c - last[i];
          last[i] = c;
        end
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (70 - last[i] > max_gap) max_gap = 70 - last[i];
    end
    checks++;
    if (cnt[0] != 10) begin errors++; $display("FAIL R9 share r0: %0d expected 10", cnt[0]); end
    checks++;
    if (cnt[1] != 10) begin errors++; $display("FAIL R9 share r1: %0d expected 10", cnt[1]); end
    checks++;
    if (cnt[2] != 20) begin errors++; $display("FAIL R9 share r2: %0d expected 20", cnt[2]); end
    checks++;
    if (cnt[3] != 30) begin errors++; $display("FAIL R9 share r3: %0d expected 30", cnt[3]); end
    checks++;
    if (max_gap > 7) begin errors++; $display("FAIL R9 wait bound: %0d expected <= 7", max_gap); end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule